// File: doc/BRIEF.md
# Two-Wire Serial Memory Target Engine

This block is the bus-facing half of a small byte-wide non-volatile store with 256 locations. It oversamples the clock and data lines of a two-wire serial bus with the system clock and recognises START, repeated START and STOP. It checks each incoming control byte and acknowledges only its own. It then carries out the transaction the bus master asks for: it loads the word address, forwards written bytes, or streams bytes back out. The block drives the data line only through an open-drain pull-down enable.

On the inside the block sees a plain byte interface. A read port is addressed by the internal word pointer and answers in the same cycle. A write strobe hands each received byte, with its address, to a write buffer. A commit pulse tells that buffer to start the program cycle. A busy input from the programming logic makes the target fall silent on the bus, so a master can poll by acknowledge until the write has finished.

Top module: `i2c_mem_target`

## Requirements
- R1: A falling data line while the clock is high is a START, and a rising data line while the clock is high is a STOP. Either one seen in the middle of a byte drops that byte without any write strobe or commit, and a START makes the next byte a control byte again.
- R2: A control byte whose upper four bits (sent first) are 1010 is acknowledged, whatever its next three bits are. Its last bit selects the direction: 1 is a read and 0 is a write. Any other code gets no acknowledge, and the block ignores the bus until the next START.
- R3: While busy_i is high, the block acknowledges no byte at all, including its own control byte.
- R4: In a write, the first byte after the control byte loads the word pointer. Each later byte is acknowledged and produces one wr_stb pulse that carries the pointer value and the byte. The pointer then moves up by one.
- R5: A STOP that ends a write in which at least one data byte was accepted gives exactly one wr_commit pulse. A repeated START gives no commit, but it leaves the pointer where the address byte set it.
- R6: A read returns the byte at the current pointer, most significant bit first, and then moves the pointer up by one. A read with no address phase therefore continues from one past the last location accessed.
- R7: During a read, the block sends one more byte each time the master acknowledges. After a master no-acknowledge it releases the data line and stays quiet until the next START.
- R8: The pointer wraps from 255 to 0, in both reads and writes.
- R9: sda_oe changes only while the synchronised clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low |
| busy_i | input | 1 | Program cycle in progress |
| mem_addr | output | 8 | Read address, equal to the word pointer |
| mem_rdata | input | 8 | Byte stored at mem_addr |
| wr_stb | output | 1 | One-cycle strobe for a received data byte |
| wr_addr | output | 8 | Address for the strobed byte |
| wr_data | output | 8 | Strobed data byte |
| wr_commit | output | 1 | One-cycle pulse that starts the program cycle |

## Verification
The hardest states to reach are a START or STOP landing partway through a byte, and a read that runs across the top of the array. The bench's bit-level master can emit a partial byte and then break off with a START or STOP. It then proves, through the strobe count, the commit count and a later read-back, that nothing was written. A sequential read placed just below the top address, and a two-byte write at the last location, drive the pointer through its wrap. The stimulus then mixes random writes and random reads against a bench memory model.

// File: rtl/i2c_mem_target.sv
module i2c_mem_target #(
  parameter int AW = 8,
  parameter logic [3:0] DEVCODE = 4'b1010
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  input  logic          busy_i,
  output logic [AW-1:0] mem_addr,
  input  logic [7:0]    mem_rdata,
  output logic          wr_stb,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          wr_commit
);

  typedef enum logic [2:0] {S_IDLE, S_CTRL, S_ADDR, S_WDAT, S_RDAT} st_t;

  st_t           st;
  logic [2:0]    scl_p, sda_p;
  logic [3:0]    bcnt;
  logic [7:0]    sr;
  logic [AW-1:0] ptr;
  logic          acked, mack, wrote;

  wire scl_q = scl_p[1];
  wire scl_d = scl_p[2];
  wire sda_q = sda_p[1];
  wire sda_d = sda_p[2];
  wire rise  = scl_q & ~scl_d;
  wire fall  = ~scl_q & scl_d;
  wire start_c = scl_q & scl_d & sda_d & ~sda_q;
  wire stop_c  = scl_q & scl_d & ~sda_d & sda_q;
  wire ack_ok  = ~busy_i & ((st != S_CTRL) | (sr[7:4] == DEVCODE));

  assign mem_addr = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= '1; sda_p <= '1;
      st <= S_IDLE; bcnt <= '0; sr <= '0; ptr <= '0;
      acked <= 1'b0; mack <= 1'b0; wrote <= 1'b0; sda_oe <= 1'b0;
      wr_stb <= 1'b0; wr_addr <= '0; wr_data <= '0; wr_commit <= 1'b0;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
      wr_stb <= 1'b0;
      wr_commit <= 1'b0;
      if (start_c) begin
        st <= S_CTRL; bcnt <= '0; sda_oe <= 1'b0; wrote <= 1'b0;
      end else if (stop_c) begin
        st <= S_IDLE; bcnt <= '0; sda_oe <= 1'b0;
        wr_commit <= wrote; wrote <= 1'b0;
      end else if (st != S_IDLE) begin
        if (rise) begin
          if (bcnt < 4'd8) begin
            sr <= {sr[6:0], sda_q};
            bcnt <= bcnt + 4'd1;
          end else if (bcnt == 4'd8) begin
            mack <= ~sda_q;
            bcnt <= 4'd9;
          end
        end else if (fall) begin
          if (st == S_RDAT) begin
            if (bcnt >= 4'd1 && bcnt <= 4'd7) sda_oe <= ~sr[7];
            else if (bcnt == 4'd8) sda_oe <= 1'b0;
            else if (bcnt == 4'd9) begin
              bcnt <= '0;
              if (mack) begin
                sr <= mem_rdata; ptr <= ptr + 1'b1; sda_oe <= ~mem_rdata[7];
              end else begin
                st <= S_IDLE; sda_oe <= 1'b0;
              end
            end
          end else if (bcnt == 4'd8) begin
            sda_oe <= ack_ok;
            acked <= ack_ok;
            if (ack_ok && st == S_ADDR) ptr <= sr[AW-1:0];
            if (ack_ok && st == S_WDAT) begin
              wr_stb <= 1'b1; wr_addr <= ptr; wr_data <= sr;
              ptr <= ptr + 1'b1; wrote <= 1'b1;
            end
          end else if (bcnt == 4'd9) begin
            bcnt <= '0;
            sda_oe <= 1'b0;
            if (!acked) st <= S_IDLE;
            else if (st == S_CTRL && sr[0]) begin
              st <= S_RDAT; sr <= mem_rdata; ptr <= ptr + 1'b1; sda_oe <= ~mem_rdata[7];
            end else if (st == S_CTRL) st <= S_ADDR;
            else st <= S_WDAT;
          end
        end
      end
    end
  end

  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_q); // R9
  AST_BUSY_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_RDAT && $rose(sda_oe)) |-> !$past(busy_i)); // R3
  AST_STB_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> sda_oe); // R4
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (mem_addr == AW'(wr_addr + 1'b1))); // R8
  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_stb, wr_commit})); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !sda_oe); // R7

endmodule

// File: tb/test_i2c_mem_target.sv
module test_i2c_mem_target;
  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, busy = 1'b0;
  logic sda_oe, wr_stb, wr_commit;
  logic [7:0] mem_addr, wr_addr, wr_data;
  logic [7:0] arr [256];
  logic [7:0] exp_m [256];
  wire sda_line = sda_m & ~sda_oe;
  wire [7:0] mem_rdata = arr[mem_addr];
  int ntest = 0, nfail = 0, stb_cnt = 0, com_cnt = 0, r9_bad = 0;
  bit done = 0;
  logic oe_prev = 1'b0;

  always #4 clk = ~clk;

  i2c_mem_target i_i2c_mem_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .busy_i(busy), .mem_addr(mem_addr), .mem_rdata(mem_rdata), .wr_stb(wr_stb),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_commit(wr_commit));

  always @(posedge clk) begin
    if (wr_stb) begin arr[wr_addr] <= wr_data; stb_cnt++; end
    if (wr_commit) com_cnt++;
  end
  always @(negedge clk) begin
    if (rst_n && sda_oe != oe_prev && scl_m) r9_bad++;
    oe_prev <= sda_oe;
  end

  function automatic logic [7:0] model_rd(input logic [7:0] a);
    return exp_m[a];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    ntest++;
    if (!ok) begin nfail++; $display("FAIL %s actual=%0h expected=%0h", req, act, expv); end
  endtask

  task automatic hw; repeat (8) @(negedge clk); endtask
  task automatic bstart; sda_m = 1; hw; scl_m = 1; hw; sda_m = 0; hw; scl_m = 0; hw; endtask
  task automatic bstop; sda_m = 0; hw; scl_m = 1; hw; sda_m = 1; hw; endtask

  task automatic wbits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      sda_m = b[7-i]; hw; scl_m = 1; hw; scl_m = 0; repeat (2) @(negedge clk);
    end
  endtask

  task automatic wbyte(input logic [7:0] b, output bit ack);
    wbits(b, 8);
    sda_m = 1; hw; scl_m = 1; repeat (4) @(negedge clk);
    ack = !sda_line; repeat (4) @(negedge clk);
    scl_m = 0; repeat (2) @(negedge clk);
  endtask

  task automatic rbyte(input bit mack, output logic [7:0] b);
    sda_m = 1;
    for (int i = 0; i < 8; i++) begin
      hw; scl_m = 1; repeat (4) @(negedge clk);
      b = {b[6:0], sda_line}; repeat (4) @(negedge clk);
      scl_m = 0;
    end
    repeat (2) @(negedge clk); sda_m = !mack; hw; scl_m = 1; hw; scl_m = 0;
    repeat (2) @(negedge clk); sda_m = 1;
  endtask

  task automatic wr_seq(input logic [7:0] a, input int n, input string req);
    bit ack; int s0 = stb_cnt, c0 = com_cnt; logic [7:0] d;
    bstart; wbyte(8'hA0, ack); chk(ack, "R2", ack, 1);
    wbyte(a, ack); chk(ack, "R4", ack, 1);
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom); wbyte(d, ack); chk(ack, req, ack, 1);
      exp_m[8'(a + k)] = d;
    end
    bstop; repeat (4) @(negedge clk);
    chk(stb_cnt - s0 == n, "R4", stb_cnt - s0, n);
    chk(com_cnt - c0 == 1, "R5", com_cnt - c0, 1);
  endtask

  task automatic rd_seq(input bit random_addr, input logic [7:0] a, input int n, input string req);
    bit ack; logic [7:0] d; int c0 = com_cnt;
    if (random_addr) begin
      bstart; wbyte(8'hA0, ack); wbyte(a, ack); chk(ack, "R4", ack, 1);
    end
    bstart; wbyte(8'hA1, ack); chk(ack, "R6", ack, 1);
    for (int k = 0; k < n; k++) begin
      rbyte(k != n - 1, d);
      chk(d == model_rd(8'(a + k)), req, d, model_rd(8'(a + k)));
    end
    hw; chk(sda_oe == 0, "R7", sda_oe, 0);
    bstop; repeat (4) @(negedge clk);
    chk(com_cnt == c0, "R5", com_cnt, c0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nfail++; $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", ntest, nfail);
      $finish;
    end
  end

  initial begin
    bit ack; logic [7:0] d; int s0, c0;
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) begin arr[i] = 8'($urandom); exp_m[i] = arr[i]; end
    repeat (5) @(negedge clk); rst_n = 1; repeat (3) @(negedge clk);
    chk(sda_oe == 0 && wr_stb == 0 && wr_commit == 0, "R9 reset", sda_oe, 0);
    chk(mem_addr == 0, "R6 reset pointer", mem_addr, 0);

    bstart; wbyte(8'h50, ack); chk(!ack, "R2 wrong code", ack, 0);
    wbyte(8'h10, ack); chk(!ack, "R2 ignored after nack", ack, 0); bstop;

    wr_seq(8'h10, 1, "R4");
    rd_seq(1, 8'h10, 1, "R6 random read");
    rd_seq(0, 8'h11, 1, "R6 current address");

    busy = 1;
    bstart; wbyte(8'hA0, ack); chk(!ack, "R3 busy write ctrl", ack, 0); bstop;
    bstart; wbyte(8'hA1, ack); chk(!ack, "R3 busy read ctrl", ack, 0); bstop;
    busy = 0;

    bstart; wbyte(8'hAE, ack); chk(ack, "R2 dont-care bits", ack, 1); bstop;
    bstart; wbyte(8'hA7, ack); chk(ack, "R2 dont-care read", ack, 1);
    rbyte(0, d); bstop;

    s0 = stb_cnt; c0 = com_cnt;
    bstart; wbits(8'hA0, 4); bstart; wbyte(8'hA0, ack);
    chk(ack, "R1 start mid-byte restarts", ack, 1);
    wbyte(8'h40, ack); wbits(8'h5A, 5); bstop; repeat (4) @(negedge clk);
    chk(stb_cnt == s0, "R1 stop mid-byte no strobe", stb_cnt, s0);
    chk(com_cnt == c0, "R1 stop mid-byte no commit", com_cnt, c0);
    rd_seq(1, 8'h40, 1, "R1 location untouched");

    wr_seq(8'hFF, 2, "R8 write wrap");
    rd_seq(1, 8'hFE, 4, "R8 read wrap");
    rd_seq(1, 8'h20, 5, "R7 sequential");

    for (int t = 0; t < 16; t++) begin
      logic [7:0] a = 8'($urandom);
      wr_seq(a, 1 + int'($urandom % 3), "R4 random write");
      rd_seq(1, 8'($urandom), 1 + int'($urandom % 3), "R6 random read");
    end

    chk(r9_bad == 0, "R9 sda change while scl high", r9_bad, 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", ntest, nfail);
    $finish;
  end
endmodule